// File: doc/BRIEF.md
# Two-Level Short-Descriptor Page Walker

This block turns a 32-bit virtual address into a physical frame by walking a two-level translation table of 32-bit descriptors. A requester hands it a virtual address and the table base over a valid/ready handshake. The walker then fetches the first-level descriptor through a single read port to memory. That descriptor either maps a 1 MB section straight away or points to a second-level table. When it points to a table, one more descriptor is fetched, and that descriptor maps either a 64 KB large page or a 4 KB small page.

The result goes back over a second valid/ready handshake. It carries the physical frame number (the physical address shifted right by the offset width), the offset width itself, a four-bit domain, a global flag, a secure flag and a fault indication with its level. A second-level mapping does not use its own bits for the domain or the secure flag. It takes both from the first-level descriptor that pointed to its table. The walker handles one walk at a time and takes a new request only after the previous response has been accepted.

Top module: `pgw_top`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and rsp_valid is 0.
- R2: The first memory read of a walk is at address tbl_base + 4 * VA[31:20].
- R3: A first-level descriptor with bits [1:0] = 0 (fault) or 3 (reserved) ends the walk with rsp_fault = 1 and rsp_fault_lvl2 = 0. No second read is issued, and frame, offset width, domain, global and secure are all 0.
- R4: A first-level descriptor with bits [1:0] = 2 is a section. The frame is bits [31:20] zero-extended, the offset width is 20, the domain is bits [8:5], global is the inverse of bit 17 and secure is the inverse of bit 19 (0 if HAS_SECURITY is 0).
- R5: A first-level descriptor with bits [1:0] = 1 is a table pointer. The second read is at {L1[31:10], VA[19:12], 2'b00}.
- R6: For a second-level descriptor, bits [1:0] = 1 is a large page (frame = bits [31:16], offset width 16), and bit 1 = 1 is a small page (frame = bits [31:12], offset width 12). Global is the inverse of bit 11.
- R7: A second-level result reports the domain from first-level bits [8:5] and secure as the inverse of first-level bit 3 (0 if HAS_SECURITY is 0), whatever the second-level descriptor holds in those positions.
- R8: A second-level descriptor with bits [1:0] = 0 gives rsp_fault = 1 and rsp_fault_lvl2 = 1, with all other result fields 0.
- R9: From the accepted request until the response is taken, req_ready is 0. While rsp_valid is 1 and rsp_ready is 0, rsp_valid and every response field stay unchanged.
- R10: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid stays 1 and mem_addr stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Byte address of the first-level table |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Descriptor read from memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_frame | output | 20 | Physical address shifted right by the offset width |
| rsp_offbits | output | 5 | Page offset width: 12, 16 or 20 (0 on fault) |
| rsp_domain | output | 4 | Domain of the mapping |
| rsp_global | output | 1 | Mapping is not tied to an address space identifier |
| rsp_secure | output | 1 | Mapping targets the secure physical space |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_lvl2 | output | 1 | Fault was raised at the second level |

## Verification
The assertions assume that memory returns exactly one mem_rsp_valid pulse for each accepted read, and only after that read has been accepted. They also assume that mem_rsp_valid stays low at every other time. The bench enforces this by acting as the memory itself. It raises mem_rsp_valid for a single cycle only after it has seen its own mem_req_ready handshake, and it always holds off the first read by one cycle so that the hold rule is exercised. The requester side follows the handshake in the same way: req_valid is asserted only while the bench waits for req_ready, and rsp_ready is held low for one cycle before each response is taken.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int DESC_W  = 32;
  localparam int ADDR_W  = 32;
  localparam int FRAME_W = 20;
  localparam int OFFB_W  = 5;
  localparam int DOM_W   = 4;
  localparam int L1_IDX_W = 12;
  localparam int L2_IDX_W = 8;

  localparam logic [OFFB_W-1:0] OFF_SECTION = OFFB_W'(20);
  localparam logic [OFFB_W-1:0] OFF_LARGE   = OFFB_W'(16);
  localparam logic [OFFB_W-1:0] OFF_SMALL   = OFFB_W'(12);

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_t;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic [OFFB_W-1:0]  offbits;
    logic [DOM_W-1:0]   domain;
    logic               glob;
    logic               sec;
    logic               fault;
    logic               fault_l2;
  } walk_result_t;

  // First-level descriptor address: table base plus four bytes per 1 MB index
  function automatic logic [ADDR_W-1:0] l1_desc_addr(
      input logic [ADDR_W-1:0] base, input logic [L1_IDX_W-1:0] idx);
    return base + {{(ADDR_W-L1_IDX_W-2){1'b0}}, idx, 2'b00};
  endfunction

  // Second-level descriptor address: pointer bits above 1 KB joined with page index
  function automatic logic [ADDR_W-1:0] l2_desc_addr(
      input logic [DESC_W-11:0] ptr, input logic [L2_IDX_W-1:0] idx);
    return {ptr, idx, 2'b00};
  endfunction
endpackage

// File: rtl/pgw_l1_decode.sv
module pgw_l1_decode
  import pgw_pkg::*;
#(
  parameter bit HAS_SECURITY = 1'b1
) (
  input  logic [DESC_W-1:0] desc,
  output logic              is_table,
  output logic              is_fault,
  output walk_result_t      sect_res,
  output logic [DOM_W-1:0]  par_domain,
  output logic              par_secure
);
  logic is_section;
  logic unused_l1_bits;

  assign is_table   = (desc[1:0] == 2'd1);
  assign is_section = (desc[1:0] == 2'd2);
  assign is_fault   = !is_table && !is_section;

  assign par_domain = desc[8:5];
  assign par_secure = HAS_SECURITY && !desc[3];

  always_comb begin
    sect_res = '0;
    if (is_section) begin
      sect_res.frame   = {{(FRAME_W-12){1'b0}}, desc[31:20]};
      sect_res.offbits = OFF_SECTION;
      sect_res.domain  = desc[8:5];
      sect_res.glob    = !desc[17];
      sect_res.sec     = HAS_SECURITY && !desc[19];
    end else if (is_fault) begin
      sect_res.fault   = 1'b1;
    end
  end

  assign unused_l1_bits = ^{desc[18], desc[16:9], desc[4], desc[2]};
endmodule

// File: rtl/pgw_l2_decode.sv
module pgw_l2_decode
  import pgw_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [DOM_W-1:0]  par_domain,
  input  logic              par_secure,
  output walk_result_t      page_res
);
  logic unused_l2_bits;

  always_comb begin
    page_res = '0;
    if (desc[1:0] == 2'd0) begin
      page_res.fault    = 1'b1;
      page_res.fault_l2 = 1'b1;
    end else begin
      if (desc[1]) begin
        page_res.frame   = desc[31:12];
        page_res.offbits = OFF_SMALL;
      end else begin
        page_res.frame   = {{(FRAME_W-16){1'b0}}, desc[31:16]};
        page_res.offbits = OFF_LARGE;
      end
      page_res.domain = par_domain;
      page_res.glob   = !desc[11];
      page_res.sec    = par_secure;
    end
  end

  assign unused_l2_bits = ^desc[10:2];
endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
(
  input  logic                phase_l2,
  input  logic [ADDR_W-1:0]   base,
  input  logic [ADDR_W-13:0]  va_hi,
  input  logic [DESC_W-1:0]   l1_desc,
  output logic [ADDR_W-1:0]   addr
);
  logic unused_ptr_bits;

  assign addr = phase_l2 ? l2_desc_addr(l1_desc[31:10], va_hi[7:0])
                         : l1_desc_addr(base, va_hi[19:8]);

  assign unused_ptr_bits = ^l1_desc[9:0];
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
#(
  parameter bit HAS_SECURITY = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [31:0]  req_va,
  input  logic [31:0]  tbl_base,
  output logic         mem_req_valid,
  input  logic         mem_req_ready,
  output logic [31:0]  mem_addr,
  input  logic         mem_rsp_valid,
  input  logic [31:0]  mem_rsp_data,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [19:0]  rsp_frame,
  output logic [4:0]   rsp_offbits,
  output logic [3:0]   rsp_domain,
  output logic         rsp_global,
  output logic         rsp_secure,
  output logic         rsp_fault,
  output logic         rsp_fault_lvl2
);
  walk_state_t          state_q;
  logic [ADDR_W-13:0]   va_q;
  logic [ADDR_W-1:0]    base_q;
  logic [DESC_W-1:0]    l1_q;
  walk_result_t         res_q;

  logic [DESC_W-1:0]    l1_dec_in;
  logic                 l1_is_table;
  logic                 l1_is_fault;
  walk_result_t         l1_res;
  walk_result_t         l2_res;
  logic [DOM_W-1:0]     par_domain;
  logic                 par_secure;

  // Named events for the checker
  logic ev_accept;
  logic ev_l1_table;
  logic ev_l1_fault;
  logic ev_l2_done;

  assign l1_dec_in = (state_q == ST_L1_WAIT) ? mem_rsp_data : l1_q;

  pgw_l1_decode #(.HAS_SECURITY(HAS_SECURITY)) u_l1_dec (
    .desc       (l1_dec_in),
    .is_table   (l1_is_table),
    .is_fault   (l1_is_fault),
    .sect_res   (l1_res),
    .par_domain (par_domain),
    .par_secure (par_secure)
  );

  pgw_l2_decode u_l2_dec (
    .desc       (mem_rsp_data),
    .par_domain (par_domain),
    .par_secure (par_secure),
    .page_res   (l2_res)
  );

  pgw_addr_gen u_addr (
    .phase_l2 (state_q == ST_L2_REQ),
    .base     (base_q),
    .va_hi    (va_q),
    .l1_desc  (l1_q),
    .addr     (mem_addr)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign rsp_valid     = (state_q == ST_DONE);

  assign ev_accept   = req_valid && req_ready;
  assign ev_l1_table = (state_q == ST_L1_WAIT) && mem_rsp_valid && l1_is_table;
  assign ev_l1_fault = (state_q == ST_L1_WAIT) && mem_rsp_valid && l1_is_fault;
  assign ev_l2_done  = (state_q == ST_L2_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      l1_q    <= '0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ev_accept) begin
          va_q    <= req_va[31:12];
          base_q  <= tbl_base;
          state_q <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          l1_q <= mem_rsp_data;
          if (l1_is_table) begin
            state_q <= ST_L2_REQ;
          end else begin
            res_q   <= l1_res;
            state_q <= ST_DONE;
          end
        end
        ST_L2_REQ: if (mem_req_ready) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (ev_l2_done) begin
          res_q   <= l2_res;
          state_q <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_frame      = res_q.frame;
  assign rsp_offbits    = res_q.offbits;
  assign rsp_domain     = res_q.domain;
  assign rsp_global     = res_q.glob;
  assign rsp_secure     = res_q.sec;
  assign rsp_fault      = res_q.fault;
  assign rsp_fault_lvl2 = res_q.fault_l2;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [19:0] rsp_frame,
  input logic [4:0]  rsp_offbits,
  input logic [3:0]  rsp_domain,
  input logic        rsp_global,
  input logic        rsp_secure,
  input logic        rsp_fault,
  input logic        rsp_fault_lvl2,
  input logic        ev_accept,
  input logic        ev_l1_table,
  input logic        ev_l1_fault
);
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || rsp_valid) |-> !req_ready);

  assert_accept_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_frame) &&
      $stable(rsp_offbits) && $stable(rsp_domain) && $stable(rsp_global) &&
      $stable(rsp_secure) && $stable(rsp_fault) && $stable(rsp_fault_lvl2)));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

  assert_l1_fault_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l1_fault |=> (rsp_valid && rsp_fault && !rsp_fault_lvl2 && !mem_req_valid));

  assert_fault_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_frame == 20'd0 && rsp_offbits == 5'd0));

  assert_table_reads_l2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l1_table |=> (mem_req_valid && !rsp_valid));

  assert_offbits_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |->
      (rsp_offbits == 5'd12 || rsp_offbits == 5'd16 || rsp_offbits == 5'd20));
endmodule

bind pgw_top pgw_checker u_pgw_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_addr       (mem_addr),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_frame      (rsp_frame),
  .rsp_offbits    (rsp_offbits),
  .rsp_domain     (rsp_domain),
  .rsp_global     (rsp_global),
  .rsp_secure     (rsp_secure),
  .rsp_fault      (rsp_fault),
  .rsp_fault_lvl2 (rsp_fault_lvl2),
  .ev_accept      (ev_accept),
  .ev_l1_table    (ev_l1_table),
  .ev_l1_fault    (ev_l1_fault)
);

// File: tb/test_pgw_top.sv
module test_pgw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] tbl_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [19:0] rsp_frame;
  logic [4:0]  rsp_offbits;
  logic [3:0]  rsp_domain;
  logic        rsp_global;
  logic        rsp_secure;
  logic        rsp_fault;
  logic        rsp_fault_lvl2;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pgw_top i_pgw_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .tbl_base(tbl_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_frame(rsp_frame),
    .rsp_offbits(rsp_offbits), .rsp_domain(rsp_domain), .rsp_global(rsp_global),
    .rsp_secure(rsp_secure), .rsp_fault(rsp_fault), .rsp_fault_lvl2(rsp_fault_lvl2)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] base;
    logic [31:0] l1;
    logic [31:0] l2;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 32'h8000_0000, 32'h4560_2C02, 32'h0},             // section, secure, global
    '{32'h0030_0ABC, 32'h0001_0000, 32'hABCA_00A2, 32'h0},             // section nG + NS
    '{32'hCAFE_B123, 32'h0004_4000, 32'h0012_3461, 32'h7654_3802},     // small page, nG
    '{32'h0000_F000, 32'h0000_8000, 32'h0FED_CDE9, 32'h1111_0001},     // large page, non-secure parent
    '{32'h7FFF_FFFF, 32'h0010_0000, 32'hFFFF_FC01, 32'hFFFF_F1FF},     // small page type 3, all ones
    '{32'h0000_0000, 32'h2000_0000, 32'h0000_0000, 32'h0},             // L1 fault type 0
    '{32'h89AB_CDEF, 32'h3000_0000, 32'hFFFF_FFFF, 32'h0},             // L1 reserved type 3
    '{32'h5555_5555, 32'h4000_4000, 32'h0ABC_D421, 32'hFFFF_FFFC},     // L2 invalid
    '{32'hFFFF_FFFF, 32'h0000_C000, 32'hFFFF_FFFE, 32'h0},             // section all ones, top index
    '{32'h0ABC_1000, 32'h0000_4000, 32'h0000_0001, 32'h0000_0802}      // table at 0, domain 0
  };

  // Expected result {frame, offbits, domain, global, secure, fault, fault_l2}
  function automatic logic [32:0] expect_res(input logic [31:0] d1, input logic [31:0] d2);
    logic [32:0] r;
    r = '0;
    case (d1[1:0])
      2'd2: r = {8'h00, d1[31:20], 5'd20, d1[8:5], ~d1[17], ~d1[19], 2'b00};   // R4
      2'd1: begin
        if (d2[1:0] == 2'b00) r = {31'd0, 2'b11};                               // R8
        else if (d2[1:0] == 2'b01)
          r = {4'h0, d2[31:16], 5'd16, d1[8:5], ~d2[11], ~d1[3], 2'b00};        // R6, R7
        else
          r = {d2[31:12], 5'd12, d1[8:5], ~d2[11], ~d1[3], 2'b00};              // R6, R7
      end
      default: r = {31'd0, 2'b10};                                             // R3
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_mem_req(output bit seen);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (mem_req_valid) begin seen = 1; break; end
      if (rsp_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic serve_read(input logic [31:0] data);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
  endtask

  task automatic run_walk(input vec_t v, input int idx);
    bit seen;
    logic [31:0] a0;
    logic [32:0] got;
    @(negedge clk);
    req_valid = 1'b1; req_va = v.va; tbl_base = v.base;
    for (int i = 0; i < 20 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_va = 32'h0BAD_F00D; tbl_base = 32'h0BAD_0000;
    // First read; held off one cycle
    wait_mem_req(seen);
    check($sformatf("R2 vec%0d first read issued", idx), 64'(seen), 64'd1);
    a0 = mem_addr;
    check($sformatf("R2 vec%0d L1 address", idx), 64'(a0),
          64'(v.base + {18'd0, v.va[31:20], 2'b00}));
    @(negedge clk);
    check($sformatf("R10 vec%0d request held", idx), {mem_req_valid, mem_addr}, {1'b1, a0});
    check($sformatf("R9 vec%0d busy", idx), 64'(req_ready), 64'd0);
    serve_read(v.l1);
    wait_mem_req(seen);
    if (v.l1[1:0] == 2'd1) begin
      check($sformatf("R5 vec%0d second read issued", idx), 64'(seen), 64'd1);
      check($sformatf("R5 vec%0d L2 address", idx), 64'(mem_addr),
            64'({v.l1[31:10], v.va[19:12], 2'b00}));
      serve_read(v.l2);
    end else begin
      check($sformatf("R3 vec%0d no second read", idx), 64'(seen), 64'd0);
    end
    for (int i = 0; i < 20 && !rsp_valid; i++) @(negedge clk);
    got = {rsp_frame, rsp_offbits, rsp_domain, rsp_global, rsp_secure, rsp_fault, rsp_fault_lvl2};
    check($sformatf("R4/R6/R7/R8 vec%0d result", idx), 64'(got), 64'(expect_res(v.l1, v.l2)));
    @(negedge clk);
    check($sformatf("R9 vec%0d response held", idx),
          {rsp_valid, req_ready, rsp_frame, rsp_offbits, rsp_domain, rsp_global,
           rsp_secure, rsp_fault, rsp_fault_lvl2}, {2'b10, got});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check($sformatf("R9 vec%0d released", idx), {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {req_ready, mem_req_valid, rsp_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {req_ready, mem_req_valid, rsp_valid}, 3'b100);
    for (int k = 0; k < NVEC; k++) run_walk(VECS[k], k);
    // Directed: reset in the middle of a walk returns to idle
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h1000_0000; tbl_base = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-walk", {req_ready, mem_req_valid, rsp_valid}, 3'b100);
    rst_n = 1'b1;
    // Directed: walk after mid-walk reset still works
    run_walk('{32'h0010_0000, 32'h0000_0000, 32'h0010_0C02, 32'h0}, 99);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule